// File: doc/BRIEF.md
# Dual-Port Reshapeable Block Memory

This block is a true dual-port synchronous memory. It holds 16,384 data bits and 2,048 parity bits. Each of its two ports has its own clock, enable, write strobe, synchronous output preset, address, data and parity inputs, and registered data and parity outputs. One elaboration parameter sets the word width that both ports share. That width fixes the depth and the address width, so a single fixed storage capacity is reshaped into six depth/width ratios. In the three wide shapes, one parity bit is carried per data byte.

A port with its enable high acts on its active clock edge, and it does exactly one of three things. A preset loads a constant into the output register. A write stores the word and also loads the written word into the output register (write-through). A read loads the addressed word into the output register. A port with its enable low does nothing at all. Each port can be set to act on the rising or the falling edge of its own clock. Data written through one port can be read through the other port.

Top module: `dpram_shaped`

## Requirements
- R1: `DATA_W` is one of 1, 2, 4, 8, 16 or 32. The depth is 16384/`DATA_W` words and the address is log2 of the depth wide (14 bits at width 1 down to 9 bits at width 32). Every address from 0 to depth-1 stores its own word.
- R2: With enable high, write strobe low and preset low, the active edge loads the word and parity stored at the port address into the output register. The value is visible after that edge.
- R3: With enable and write strobe high, the active edge stores the data input and the parity input at the port address.
- R4: On a write edge, the output register takes the data and parity being written in that edge. It never shows the previous contents of the location.
- R5: With enable low, the port writes nothing and reads nothing, and its outputs keep their previous value whatever the other inputs do.
- R6: With enable and preset high, the active edge loads the output register with the port's init parameter: data from bits `DATA_W-1:0` and parity from the bits just above them. This takes priority over read data and over write-through data. A write strobed in the same edge is still stored.
- R7: For `DATA_W` of 8 or more, the parity bus is `DATA_W/8` bits wide and is stored next to the data. For widths 1, 2 and 4, the parity bus is 1 bit wide, its input is ignored and its output always reads 0.
- R8: The two ports share one storage. A word written through either port is read back unchanged through the other port, with each port on its own clock.
- R9: Each port has a parameter (`FALL_A`, `FALL_B`). When it is 1, the port acts only on the falling edge of its clock. When it is 0, the port acts only on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write strobe |
| ssr_a | input | 1 | Port A synchronous output preset |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| pin_a | input | PBUS_W | Port A write parity |
| dout_a | output | DATA_W | Port A registered read data |
| pout_a | output | PBUS_W | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write strobe |
| ssr_b | input | 1 | Port B synchronous output preset |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| pin_b | input | PBUS_W | Port B write parity |
| dout_b | output | DATA_W | Port B registered read data |
| pout_b | output | PBUS_W | Port B registered read parity |

## Verification
The storage is split into two banks, and a word is only correct when both banks agree. So a corrupt bank update does not show up on the write edge, because write-through bypasses the storage. It shows up on the first later read of that address, from either port, one active edge after the read is issued. A wrong output-register state (a missed hold, a lost preset, or stale data on a write) is visible on that port right after the offending edge. Wrong edge selection is caught by sampling the output between the two edges of the same clock cycle.

// File: rtl/bram_shape_pkg.sv
package bram_shape_pkg;

  localparam int DATA_BITS = 16384;
  localparam int PAR_BITS  = 2048;
  localparam int INIT_W    = 36;

  function automatic bit shape_ok(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
  endfunction

  function automatic int depth_of(input int w);
    return DATA_BITS / w;
  endfunction

  function automatic bit has_par(input int w);
    return w >= 8;
  endfunction

  // parity bus keeps a one-bit stub in the narrow shapes
  function automatic int pbus_of(input int w);
    return (w >= 8) ? (w / 8) : 1;
  endfunction

endpackage

// File: rtl/bram_edge_sel.sv
module bram_edge_sel #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  output logic clk_o
);
  generate
    if (FALLING) begin : g_fall
      assign clk_o = ~clk_i;
    end else begin : g_rise
      assign clk_o = clk_i;
    end
  endgenerate
endmodule

// File: rtl/bram_xor_bank.sv
// One bank of a two-bank XOR store. Only the owning port writes it;
// both ports read it asynchronously.
module bram_xor_bank #(
  parameter int DEPTH  = 512,
  parameter int WORD_W = 36,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr_self,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_self,
  input  logic [ADDR_W-1:0] addr_peer,
  output logic [WORD_W-1:0] rd_peer
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr_self] <= wdata;
  end

  assign rd_self = mem[addr_self];
  assign rd_peer = mem[addr_peer];
endmodule

// File: rtl/bram_port_ctl.sv
module bram_port_ctl #(
  parameter int              DATA_W  = 32,
  parameter int              PBUS_W  = 4,
  parameter bit              HAS_PAR = 1'b1,
  parameter int              ADDR_W  = 9,
  parameter logic [35:0]     INIT    = '0
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic                     ssr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        din,
  input  logic [PBUS_W-1:0]        pin,
  input  logic [DATA_W+PBUS_W-1:0] own_rd,
  input  logic [DATA_W+PBUS_W-1:0] oth_rd,
  output logic                     bank_we,
  output logic [DATA_W+PBUS_W-1:0] bank_wdata,
  output logic [DATA_W-1:0]        dout,
  output logic [PBUS_W-1:0]        pout
);
  localparam int WORD_W = DATA_W + PBUS_W;

  logic [PBUS_W-1:0] par_in;
  logic [PBUS_W-1:0] init_par;
  logic [PBUS_W-1:0] rd_par;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] sum_word;
  logic [WORD_W-1:0] out_q;

  assign sum_word = own_rd ^ oth_rd;

  generate
    if (HAS_PAR) begin : g_par
      assign par_in   = pin;
      assign init_par = INIT[DATA_W +: PBUS_W];
      assign rd_par   = sum_word[WORD_W-1:DATA_W];
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{pin, sum_word[WORD_W-1:DATA_W]};
      assign par_in   = '0;
      assign init_par = '0;
      assign rd_par   = '0;
    end
  endgenerate

  assign wr_word    = {par_in, din};
  assign bank_we    = en & we;
  assign bank_wdata = wr_word ^ oth_rd;

  always_ff @(posedge clk) begin
    if (en) begin
      if (ssr)     out_q <= {init_par, INIT[DATA_W-1:0]};
      else if (we) out_q <= wr_word;
      else         out_q <= {rd_par, sum_word[DATA_W-1:0]};
    end
  end

  assign dout = out_q[DATA_W-1:0];
  assign pout = out_q[WORD_W-1:DATA_W];

  // R5: idle port holds its output
  p_hold_r5: assert property (@(posedge clk) disable iff (ssr)
    !en |=> $stable({pout, dout}));

  // R4: write-through shows the new word
  p_wr_first_r4: assert property (@(posedge clk) disable iff (ssr)
    (en && we) |=> {pout, dout} == $past({par_in, din}));

  // R6: preset loads the init constant
  p_preset_r6: assert property (@(posedge clk) disable iff (!en)
    ssr |=> dout == INIT[DATA_W-1:0]);

  // R3: read right after own write at the same address returns that word
  p_rd_after_wr_r3: assert property (@(posedge clk) disable iff (ssr)
    (en && we) ##1 (en && !we && addr == $past(addr)) |=> {pout, dout} == $past({pout, dout}));

  generate
    if (!HAS_PAR) begin : g_chk_nopar
      // R7: narrow shapes never present parity
      p_no_par_r7: assert property (@(posedge clk) disable iff (ssr)
        en |=> pout == '0);
    end
  endgenerate
endmodule

// File: rtl/dpram_shaped.sv
module dpram_shaped
  import bram_shape_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter bit          FALL_A = 1'b0,
  parameter bit          FALL_B = 1'b0,
  parameter logic [35:0] INIT_A = '0,
  parameter logic [35:0] INIT_B = '0,
  localparam int         DEPTH  = depth_of(DATA_W),
  localparam int         ADDR_W = $clog2(DEPTH),
  localparam int         PBUS_W = pbus_of(DATA_W)
) (
  input  logic              clk_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic              ssr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic [PBUS_W-1:0] pin_a,
  output logic [DATA_W-1:0] dout_a,
  output logic [PBUS_W-1:0] pout_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic              ssr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  input  logic [PBUS_W-1:0] pin_b,
  output logic [DATA_W-1:0] dout_b,
  output logic [PBUS_W-1:0] pout_b
);
  localparam bit HAS_PAR = has_par(DATA_W);
  localparam int WORD_W  = DATA_W + PBUS_W;

  generate
    if (!shape_ok(DATA_W)) begin : g_bad_shape
      $error("dpram_shaped: DATA_W must be 1, 2, 4, 8, 16 or 32");
    end
  endgenerate

  logic              ck_a, ck_b;
  logic              bwe_a, bwe_b;
  logic [WORD_W-1:0] bwd_a, bwd_b;
  logic [WORD_W-1:0] a_self, a_peer, b_self, b_peer;

  bram_edge_sel #(.FALLING(FALL_A)) u_edge_a (.clk_i(clk_a), .clk_o(ck_a));
  bram_edge_sel #(.FALLING(FALL_B)) u_edge_b (.clk_i(clk_b), .clk_o(ck_b));

  bram_xor_bank #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank_a (
    .clk(ck_a), .we(bwe_a), .addr_self(addr_a), .wdata(bwd_a),
    .rd_self(a_self), .addr_peer(addr_b), .rd_peer(a_peer));

  bram_xor_bank #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank_b (
    .clk(ck_b), .we(bwe_b), .addr_self(addr_b), .wdata(bwd_b),
    .rd_self(b_self), .addr_peer(addr_a), .rd_peer(b_peer));

  bram_port_ctl #(.DATA_W(DATA_W), .PBUS_W(PBUS_W), .HAS_PAR(HAS_PAR),
                  .ADDR_W(ADDR_W), .INIT(INIT_A)) u_port_a (
    .clk(ck_a), .en(en_a), .we(we_a), .ssr(ssr_a), .addr(addr_a),
    .din(din_a), .pin(pin_a), .own_rd(a_self), .oth_rd(b_peer),
    .bank_we(bwe_a), .bank_wdata(bwd_a), .dout(dout_a), .pout(pout_a));

  bram_port_ctl #(.DATA_W(DATA_W), .PBUS_W(PBUS_W), .HAS_PAR(HAS_PAR),
                  .ADDR_W(ADDR_W), .INIT(INIT_B)) u_port_b (
    .clk(ck_b), .en(en_b), .we(we_b), .ssr(ssr_b), .addr(addr_b),
    .din(din_b), .pin(pin_b), .own_rd(b_self), .oth_rd(a_peer),
    .bank_we(bwe_b), .bank_wdata(bwd_b), .dout(dout_b), .pout(pout_b));
endmodule

// File: tb/sim_dpram_shaped.sv
module sim_dpram_shaped;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 16;
  localparam logic [35:0] INIT_A = 36'hF_DEAD_BEEF;
  localparam logic [35:0] INIT_B = 36'h3_0000_1234;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  // u0: 512 x (32+4), port B on the falling edge
  logic a_en = 0, a_we = 0, a_ssr = 0, b_en = 0, b_we = 0, b_ssr = 0;
  logic [8:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_din = '0, b_din = '0, a_dout, b_dout;
  logic [3:0]  a_pin = '0, b_pin = '0, a_pout, b_pout;

  dpram_shaped #(.DATA_W(32), .FALL_A(1'b0), .FALL_B(1'b1),
                 .INIT_A(INIT_A), .INIT_B(INIT_B)) u0 (
    .clk_a(clk_a), .en_a(a_en), .we_a(a_we), .ssr_a(a_ssr), .addr_a(a_addr),
    .din_a(a_din), .pin_a(a_pin), .dout_a(a_dout), .pout_a(a_pout),
    .clk_b(clk_b), .en_b(b_en), .we_b(b_we), .ssr_b(b_ssr), .addr_b(b_addr),
    .din_b(b_din), .pin_b(b_pin), .dout_b(b_dout), .pout_b(b_pout));

  // u1: 4096 x 4, no parity, both rising
  logic na_en = 0, na_we = 0, nb_en = 0, nb_we = 0;
  logic [11:0] na_addr = '0, nb_addr = '0;
  logic [3:0]  na_din = '0, nb_din = '0, na_dout, nb_dout;
  logic        na_pin = 0, nb_pin = 0, na_pout, nb_pout;

  dpram_shaped #(.DATA_W(4)) u1 (
    .clk_a(clk_a), .en_a(na_en), .we_a(na_we), .ssr_a(1'b0), .addr_a(na_addr),
    .din_a(na_din), .pin_a(na_pin), .dout_a(na_dout), .pout_a(na_pout),
    .clk_b(clk_b), .en_b(nb_en), .we_b(nb_we), .ssr_b(1'b0), .addr_b(nb_addr),
    .din_b(nb_din), .pin_b(nb_pin), .dout_b(nb_dout), .pout_b(nb_pout));

  typedef struct packed {
    logic        port;   // 0 = A, 1 = B
    logic        en;
    logic        we;
    logic        ssr;
    logic [8:0]  addr;
    logic [31:0] din;
    logic [3:0]  pin;
    logic [31:0] ed;
    logic [3:0]  ep;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,9'd5,  32'h1111_2222,4'h3, 32'h1111_2222,4'h3, 4'd4}, // R4 write-through
    '{1'b0,1'b1,1'b0,1'b0,9'd5,  32'h0,        4'h0, 32'h1111_2222,4'h3, 4'd2}, // R2 read, R3 stored
    '{1'b1,1'b1,1'b1,1'b0,9'd9,  32'hCAFE_F00D,4'hA, 32'hCAFE_F00D,4'hA, 4'd9}, // R9 falling port writes
    '{1'b0,1'b1,1'b0,1'b0,9'd9,  32'h0,        4'h0, 32'hCAFE_F00D,4'hA, 4'd8}, // R8 B->A
    '{1'b1,1'b1,1'b0,1'b0,9'd5,  32'h0,        4'h0, 32'h1111_2222,4'h3, 4'd8}, // R8 A->B
    '{1'b0,1'b0,1'b1,1'b0,9'd5,  32'hFFFF_FFFF,4'hF, 32'hCAFE_F00D,4'hA, 4'd5}, // R5 hold
    '{1'b0,1'b1,1'b0,1'b0,9'd5,  32'h0,        4'h0, 32'h1111_2222,4'h3, 4'd5}, // R5 no write
    '{1'b0,1'b1,1'b0,1'b1,9'd9,  32'h0,        4'h0, 32'hDEAD_BEEF,4'hF, 4'd6}, // R6 preset over read
    '{1'b0,1'b1,1'b0,1'b0,9'd9,  32'h0,        4'h0, 32'hCAFE_F00D,4'hA, 4'd6}, // R6 memory kept
    '{1'b1,1'b1,1'b1,1'b1,9'd20, 32'h0000_0055,4'h1, 32'h0000_1234,4'h3, 4'd6}, // R6 preset over write
    '{1'b1,1'b1,1'b0,1'b0,9'd20, 32'h0,        4'h0, 32'h0000_0055,4'h1, 4'd6}, // R6 write kept
    '{1'b0,1'b1,1'b1,1'b0,9'd511,32'h8000_0001,4'h8, 32'h8000_0001,4'h8, 4'd1}, // R1 top address
    '{1'b0,1'b1,1'b1,1'b0,9'd0,  32'h0000_0007,4'h0, 32'h0000_0007,4'h0, 4'd1}, // R1 bottom address
    '{1'b1,1'b1,1'b0,1'b0,9'd511,32'h0,        4'h0, 32'h8000_0001,4'h8, 4'd1}, // R1
    '{1'b0,1'b1,1'b0,1'b0,9'd0,  32'h0,        4'h0, 32'h0000_0007,4'h0, 4'd1}, // R1
    '{1'b0,1'b0,1'b0,1'b0,9'd511,32'h0,        4'h0, 32'h0000_0007,4'h0, 4'd5}, // R5 idle read
    '{1'b1,1'b1,1'b1,1'b0,9'd5,  32'h0BAD_C0DE,4'h5, 32'h0BAD_C0DE,4'h5, 4'd3}, // R3 overwrite
    '{1'b0,1'b1,1'b0,1'b0,9'd5,  32'h0,        4'h0, 32'h0BAD_C0DE,4'h5, 4'd7}  // R7 parity kept
  };

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input int req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    if (!v.port) begin
      @(negedge clk_a);
      a_en = v.en; a_we = v.we; a_ssr = v.ssr; a_addr = v.addr; a_din = v.din; a_pin = v.pin;
      @(posedge clk_a); #2;
      chk(int'(v.req), {a_pout, a_dout}, {v.ep, v.ed});
      a_en = 0; a_we = 0; a_ssr = 0;
    end else begin
      @(posedge clk_b);
      b_en = v.en; b_we = v.we; b_ssr = v.ssr; b_addr = v.addr; b_din = v.din; b_pin = v.pin;
      @(negedge clk_b); #2;
      chk(int'(v.req), {b_pout, b_dout}, {v.ep, v.ed});
      b_en = 0; b_we = 0; b_ssr = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_a);
    // R6 initial state through preset on both ports
    run_op('{1'b0,1'b1,1'b0,1'b1,9'd0,32'h0,4'h0,32'hDEAD_BEEF,4'hF,4'd6});
    run_op('{1'b1,1'b1,1'b0,1'b1,9'd0,32'h0,4'h0,32'h0000_1234,4'h3,4'd6});

    for (int i = 0; i < NV; i++) run_op(VEC[i]);

    // R9: falling-edge port ignores the rising edge
    @(negedge clk_b); #2;
    b_en = 1; b_we = 1; b_addr = 9'd40; b_din = 32'h1234_5678; b_pin = 4'h2;
    @(posedge clk_b); #2;
    chk(9, {b_pout, b_dout}, {4'h5, 32'h0BAD_C0DE});   // R9 still last B value
    @(negedge clk_b); #2;
    chk(9, {b_pout, b_dout}, {4'h2, 32'h1234_5678});   // R9 acts on falling edge
    b_en = 0; b_we = 0;

    // R7 narrow shape: parity input ignored, output zero
    @(negedge clk_a);
    na_en = 1; na_we = 1; na_addr = 12'd4095; na_din = 4'h9; na_pin = 1'b1;
    @(posedge clk_a); #2;
    chk(7, {na_pout, na_dout}, {1'b0, 4'h9});           // R7 write-through, R4
    na_addr = 12'd0; na_din = 4'h6;
    @(posedge clk_a); #2;
    chk(4, {na_pout, na_dout}, {1'b0, 4'h6});           // R4 second write
    na_en = 0; na_we = 0;
    @(negedge clk_b);
    nb_en = 1; nb_addr = 12'd4095;
    @(posedge clk_b); #2;
    chk(1, {nb_pout, nb_dout}, {1'b0, 4'h9});           // R1 12-bit top address, R8
    nb_addr = 12'd0;
    @(posedge clk_b); #2;
    chk(7, {nb_pout, nb_dout}, {1'b0, 4'h6});           // R7 parity reads 0
    nb_en = 0;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule